// File: doc/BRIEF.md
# Hard-Value Output Register with Read Sequencing

This block is the read-only result port of a convolutional coding and equalization coprocessor. An internal engine hands it one symbol at a time: a group of coded bits in encode mode, or a single bit in decode and equalize modes. Each time the processor core or a DMA channel reads the port, the next pending bit is returned as a signed full-scale 24-bit word. A logic 1 reads as 0x800000 and a logic 0 reads as 0x7FFF00. Only the upper 16 bits of the word carry information.

In encode mode, the bits of one symbol are returned in ascending tap-polynomial order, so the bit from polynomial 0 comes first. When the last bit of the symbol has been read, the block asks the engine for the next symbol. Two reads on consecutive clock cycles are illegal. Such a read is refused: it does not advance the sequence, the output holds its previous value, and a sticky flag records the violation. A read made when no bit is pending returns the logic-0 word and sets a sticky underflow flag. The pending-data output can be used as a DMA request.

Top module: `hv_out_reg`

## Requirements
- R1: After reset, rd_data_o is 0x7FFF00, data_valid_o is 0, src_ready_o is 1, and rd_viol_o and rd_undf_o are both 0.
- R2: An accepted read returns the current bit on rd_data_o in the clock cycle after the strobe. Bit value 1 maps to 0x800000 and bit value 0 maps to 0x7FFF00.
- R3: In encode mode (mode_i = 0), the bits of a symbol are returned in ascending index order, starting with src_bits_i[0], which is the bit of tap polynomial 0.
- R4: rate_i selects the number of bits per encoded symbol: 0 selects 2, 1 selects 3, 2 selects 4 and 3 selects 6. After the last of those bits is read, data_valid_o falls and src_ready_o rises in the next cycle.
- R5: In decode mode (mode_i = 1) and equalize mode (mode_i = 2 or 3), each symbol holds one bit, src_bits_i[0]. The bits above it are ignored, and one read empties the symbol.
- R6: A read strobe asserted in the cycle directly after a previous strobe cycle is refused. The bit sequence does not advance, rd_data_o keeps its value, and rd_viol_o is set.
- R7: An accepted read while data_valid_o is 0 drives rd_data_o to 0x7FFF00 and sets rd_undf_o.
- R8: A symbol is loaded when src_valid_i and src_ready_o are both high. data_valid_o is high exactly while a loaded symbol has unread bits, and src_ready_o is its inverse, so a symbol offered while one is held is not taken.
- R9: rd_viol_o and rd_undf_o stay set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 0 encode, 1 decode, 2 or 3 equalize |
| rate_i | input | 2 | Encode bits per symbol: 0→2, 1→3, 2→4, 3→6 |
| src_valid_i | input | 1 | Engine offers a symbol |
| src_bits_i | input | 6 | Symbol bits, index = tap polynomial |
| src_ready_o | output | 1 | Request for the next symbol |
| rd_i | input | 1 | Single-cycle read strobe from the core or DMA |
| rd_data_o | output | 24 | Hard-value read word |
| data_valid_o | output | 1 | Unread bit pending (DMA request) |
| rd_viol_o | output | 1 | Sticky back-to-back read flag |
| rd_undf_o | output | 1 | Sticky empty-read flag |

## Verification
The assertions check on every cycle that:
- rd_data_o always holds one of the two legal words;
- a back-to-back strobe raises the violation flag and leaves the output unchanged;
- an empty read produces the logic-0 word together with the underflow flag;
- a completed handshake loads a symbol, and the bit index stays inside the symbol;
- the two flags stay set once raised.

Only the directed scenarios can show that the bits arrive in tap order at each of the four rates, and that decode and equalize modes drop the upper bits. The scenarios also show that a refused read does not advance the sequence, and that a symbol offered while one is held is not taken.

// File: rtl/hv_out_pkg.sv
package hv_out_pkg;
  localparam int unsigned HV_W  = 24;
  localparam int unsigned SIG_W = 16;

  localparam logic [HV_W-1:0] HV_ONE  = {1'b1, {(HV_W-1){1'b0}}};
  localparam logic [HV_W-1:0] HV_ZERO = {1'b0, {(SIG_W-1){1'b1}}, {(HV_W-SIG_W){1'b0}}};

  typedef enum logic [1:0] {
    MODE_ENC  = 2'd0,
    MODE_DEC  = 2'd1,
    MODE_EQU  = 2'd2,
    MODE_EQU3 = 2'd3
  } hv_mode_e;

  function automatic logic [HV_W-1:0] hv_word(input logic b);
    return b ? HV_ONE : HV_ZERO;
  endfunction
endpackage

// File: rtl/hv_rd_guard.sv
module hv_rd_guard (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_i,
  output logic acc_o,
  output logic viol_o
);
  logic rd_q;

  assign acc_o = rd_i & ~rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q   <= 1'b0;
      viol_o <= 1'b0;
    end else begin
      rd_q <= rd_i;
      if (rd_i && rd_q) viol_o <= 1'b1;
    end
  end

  p_b2b_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && $past(rd_i)) |=> viol_o);
  p_viol_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |=> viol_o);
endmodule

// File: rtl/hv_bit_seq.sv
module hv_bit_seq #(
  parameter int unsigned SYM_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic [1:0]       rate_i,
  input  logic             src_valid_i,
  input  logic [SYM_W-1:0] src_bits_i,
  input  logic             acc_i,
  output logic             src_ready_o,
  output logic             have_o,
  output logic             cur_bit_o
);
  import hv_out_pkg::*;

  localparam int unsigned CNT_W = $clog2(SYM_W + 1);
  localparam int unsigned IDX_W = CNT_W;

  logic [SYM_W-1:0] bits_q;
  logic [CNT_W-1:0] cnt_q, load_cnt;
  logic [IDX_W-1:0] idx_q;
  logic             last_bit, adv, load;

  always_comb begin
    if (hv_mode_e'(mode_i) == MODE_ENC) begin
      unique case (rate_i)
        2'd0:    load_cnt = CNT_W'(2);
        2'd1:    load_cnt = CNT_W'(3);
        2'd2:    load_cnt = CNT_W'(4);
        default: load_cnt = CNT_W'(6);
      endcase
    end else begin
      load_cnt = CNT_W'(1);
    end
  end

  assign src_ready_o = ~have_o;
  assign load        = src_valid_i & src_ready_o;
  assign adv         = acc_i & have_o;
  assign last_bit    = (CNT_W'(idx_q) + CNT_W'(1)) == cnt_q;
  assign cur_bit_o   = bits_q[idx_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bits_q <= '0;
      cnt_q  <= '0;
      idx_q  <= '0;
      have_o <= 1'b0;
    end else if (adv) begin
      if (last_bit) begin
        idx_q  <= '0;
        have_o <= 1'b0;
      end else begin
        idx_q <= idx_q + IDX_W'(1);
      end
    end else if (load) begin
      // single-bit modes keep only bit 0
      bits_q <= (load_cnt == CNT_W'(1)) ? {{(SYM_W-1){1'b0}}, src_bits_i[0]} : src_bits_i;
      cnt_q  <= load_cnt;
      idx_q  <= '0;
      have_o <= 1'b1;
    end
  end

  p_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_valid_i && src_ready_o) |=> have_o);
  p_idx_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    have_o |-> (CNT_W'(idx_q) < cnt_q));
  p_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && last_bit) |=> (src_ready_o && idx_q == '0));
endmodule

// File: rtl/hv_map.sv
module hv_map (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        acc_i,
  input  logic                        have_i,
  input  logic                        cur_bit_i,
  output logic [hv_out_pkg::HV_W-1:0] rd_data_o,
  output logic                        undf_o
);
  import hv_out_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o <= HV_ZERO;
      undf_o    <= 1'b0;
    end else if (acc_i) begin
      if (have_i) begin
        rd_data_o <= hv_word(cur_bit_i);
      end else begin
        rd_data_o <= HV_ZERO;
        undf_o    <= 1'b1;
      end
    end
  end

  p_legal_word_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o == HV_ONE) || (rd_data_o == HV_ZERO));
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_i |=> $stable(rd_data_o));
  p_undf_word_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !have_i) |=> (undf_o && rd_data_o == HV_ZERO));
  p_undf_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undf_o |=> undf_o);
endmodule

// File: rtl/hv_out_reg.sv
module hv_out_reg #(
  parameter int unsigned SYM_W = 6
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [1:0]                  mode_i,
  input  logic [1:0]                  rate_i,
  input  logic                        src_valid_i,
  input  logic [SYM_W-1:0]            src_bits_i,
  output logic                        src_ready_o,
  input  logic                        rd_i,
  output logic [hv_out_pkg::HV_W-1:0] rd_data_o,
  output logic                        data_valid_o,
  output logic                        rd_viol_o,
  output logic                        rd_undf_o
);
  logic acc, have, cur_bit;

  hv_rd_guard u_guard (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rd_i   (rd_i),
    .acc_o  (acc),
    .viol_o (rd_viol_o)
  );

  hv_bit_seq #(.SYM_W(SYM_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode_i),
    .rate_i      (rate_i),
    .src_valid_i (src_valid_i),
    .src_bits_i  (src_bits_i),
    .acc_i       (acc),
    .src_ready_o (src_ready_o),
    .have_o      (have),
    .cur_bit_o   (cur_bit)
  );

  hv_map u_map (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .acc_i     (acc),
    .have_i    (have),
    .cur_bit_i (cur_bit),
    .rd_data_o (rd_data_o),
    .undf_o    (rd_undf_o)
  );

  assign data_valid_o = have;

  p_refused_no_adv_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !acc && have) |=> data_valid_o);
endmodule

// File: tb/hv_out_reg_test.sv
`timescale 1ns/1ps
module hv_out_reg_test;
  localparam logic [23:0] ONE  = 24'h800000;
  localparam logic [23:0] ZERO = 24'h7FFF00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'd0, rate = 2'd0;
  logic        src_valid = 1'b0;
  logic [5:0]  src_bits = '0;
  logic        src_ready;
  logic        rd = 1'b0;
  logic [23:0] rd_data;
  logic        dvalid, viol, undf;
  int          compared = 0, mismatched = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  hv_out_reg uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .rate_i(rate),
    .src_valid_i(src_valid), .src_bits_i(src_bits), .src_ready_o(src_ready),
    .rd_i(rd), .rd_data_o(rd_data), .data_valid_o(dvalid),
    .rd_viol_o(viol), .rd_undf_o(undf)
  );

  function automatic logic [23:0] hv(input logic b);
    return b ? ONE : ZERO;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input logic [5:0] b);
    @(negedge clk); src_valid = 1'b1; src_bits = b;
    @(negedge clk); src_valid = 1'b0;
  endtask

  task automatic rd_once(output logic [23:0] d);
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    d = rd_data;
  endtask

  task automatic t_reset();
    chk("R1 data", 32'(rd_data), 32'(ZERO));
    chk("R1 valid", 32'(dvalid), 0);
    chk("R1 ready", 32'(src_ready), 1);
    chk("R1 viol", 32'(viol), 0);
    chk("R1 undf", 32'(undf), 0);
  endtask

  task automatic t_encode(input logic [1:0] code, input int n, input logic [5:0] b);
    logic [23:0] d;
    mode = 2'd0; rate = code;
    push(b);
    chk("R8 valid after load", 32'(dvalid), 1);
    chk("R8 ready low while held", 32'(src_ready), 0);
    for (int i = 0; i < n; i++) begin
      rd_once(d);
      chk("R3 tap order / R2 map", 32'(d), 32'(hv(b[i])));
      if (i < n - 1) chk("R4 still pending", 32'(dvalid), 1);
    end
    chk("R4 valid after last", 32'(dvalid), 0);
    chk("R4 request next", 32'(src_ready), 1);
  endtask

  task automatic t_single(input logic [1:0] m, input logic [5:0] b);
    logic [23:0] d;
    mode = m; rate = 2'd3;
    push(b);
    rd_once(d);
    chk("R5 single bit", 32'(d), 32'(hv(b[0])));
    chk("R5 one read empties", 32'(dvalid), 0);
  endtask

  task automatic t_hold();
    logic [23:0] d;
    mode = 2'd0; rate = 2'd0;
    push(6'b000001);
    push(6'b000010);
    rd_once(d); chk("R8 held bit0", 32'(d), 32'(ONE));
    rd_once(d); chk("R8 held bit1", 32'(d), 32'(ZERO));
    chk("R8 offer not taken", 32'(dvalid), 0);
  endtask

  task automatic t_b2b();
    logic [23:0] d;
    chk("R6 no false flag", 32'(viol), 0);
    mode = 2'd0; rate = 2'd0;
    push(6'b000001);
    @(negedge clk); rd = 1'b1;
    @(negedge clk);
    chk("R2 first read", 32'(rd_data), 32'(ONE));
    @(negedge clk); rd = 1'b0;
    chk("R6 data held", 32'(rd_data), 32'(ONE));
    chk("R6 flag set", 32'(viol), 1);
    chk("R6 not advanced", 32'(dvalid), 1);
    rd_once(d);
    chk("R6 next bit intact", 32'(d), 32'(ZERO));
    chk("R6 symbol done", 32'(dvalid), 0);
  endtask

  task automatic t_underflow();
    logic [23:0] d;
    chk("R7 no false flag", 32'(undf), 0);
    t_single(2'd1, 6'b000001);
    rd_once(d);
    chk("R7 empty word", 32'(d), 32'(ZERO));
    chk("R7 flag set", 32'(undf), 1);
  endtask

  task automatic t_sticky();
    repeat (4) @(negedge clk);
    chk("R9 viol sticky", 32'(viol), 1);
    chk("R9 undf sticky", 32'(undf), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_encode(2'd0, 2, 6'b000010);
    t_encode(2'd1, 3, 6'b000101);
    t_encode(2'd2, 4, 6'b001001);
    t_encode(2'd3, 6, 6'b101101);
    t_encode(2'd3, 6, 6'b010011);
    t_single(2'd1, 6'b111110);
    t_single(2'd2, 6'b000001);
    t_single(2'd3, 6'b111110);
    t_hold();
    t_b2b();
    t_underflow();
    t_sticky();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule